// File: doc/BRIEF.md
# Two-Channel Photon Coincidence Capture

This block pairs events from two photon-detector channels and captures the raw timing data for each pair. Each detector output is a discriminated pulse that arrives asynchronously. Each channel also has an integrator whose voltage is digitised by its own ADC on every tick of the 10 ns sample clock. The block does not compute fine time. It stores the raw integrator samples so that software downstream can interpolate between clock edges later.

When either channel produces an event, the block stores that channel's ADC sample and opens a coincidence window. It then counts sample clocks while it waits for the opposite channel. If the opposite channel fires inside the window, the block stores its sample and presents one record on a valid/ready output. The record holds:
- the leader's sample,
- the follower's sample,
- the coarse cycle count,
- a flag naming the leader,
- a flag that says whether both samples lie inside the usable integrator range.

If the window runs out, the partial capture is thrown away and the block waits for the next event. Events that arrive while a finished record is still waiting to be read are counted as dropped.

Top module: `coinc_capture`

## Requirements
- R1: Each event input is synchronised, and only its rising edge counts. A pulse of any length produces exactly one event.
- R2: When channel A leads and channel B follows d cycles later (d ≥ 1), the record carries first = A's sample, second = B's sample, cycles = d and b_lead = 0.
- R3: When channel B leads by d cycles, the record carries first = B's sample, second = A's sample, cycles = d and b_lead = 1.
- R4: When both channels fire in the same cycle, the record has cycles = 0 and b_lead = 0, with first = A's sample and second = B's sample.
- R5: A follower event up to WIN_CYC cycles after the leader completes a record. With no follower by then, the capture is discarded, no record appears, and the block re-arms.
- R6: range_ok is 1 exactly when both stored samples lie in the inclusive range LO_LIM..HI_LIM (650..2350 by default).
- R7: Once rec_valid rises, rec_valid and every record field stay unchanged until rec_ready is sampled high. On the cycle after that, rec_valid is 0.
- R8: While a record is held, events on either channel are ignored and each one adds 1 to drop_cnt. Two simultaneous events add 2. The counter saturates at its all-ones value.
- R9: Reset clears rec_valid and drop_cnt to 0.
- R10: A repeated event on the leading channel during the window is ignored. The cycle count still runs from the first leader event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_a_i | input | 1 | Asynchronous discriminated event, channel A |
| evt_b_i | input | 1 | Asynchronous discriminated event, channel B |
| adc_a_i | input | ADC_W | Integrator sample stream, channel A |
| adc_b_i | input | ADC_W | Integrator sample stream, channel B |
| rec_ready_i | input | 1 | Reader accepts the record |
| rec_valid_o | output | 1 | Record present |
| rec_first_o | output | ADC_W | Leader's integrator sample |
| rec_second_o | output | ADC_W | Follower's integrator sample |
| rec_cycles_o | output | CNT_W | Sample clocks between leader and follower |
| rec_b_lead_o | output | 1 | 1 when channel B led |
| rec_range_ok_o | output | 1 | Both samples within the usable range |
| drop_cnt_o | output | DROP_W | Saturating count of events ignored while a record is held |

## Verification
The bench builds the block with WIN_CYC = 20, ADC_LAT = 2 and DROP_W = 4. The short window lets random offsets of ±24 cycles land on both sides of the timeout edge many times, including the exact boundary. The four-bit drop counter reaches saturation after a handful of ignored events. The nonzero ADC latency keeps the strobe delay line in the path, so the bench also confirms that the delay leaves the cycle count unchanged.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_HOLD = 2'd2
  } cap_state_e;
endpackage

// File: rtl/coinc_rst_sync.sv
module coinc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/coinc_edge_strobe.sv
// Two-flop synchroniser, rising-edge detect, then a delay line of LAT stages
// that lines the strobe up with the ADC output latency.
module coinc_edge_strobe #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic strobe_o
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic [LAT:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], evt_i};
      prev_q <= sync_q[1];
    end
  end

  assign chain[0] = sync_q[1] & ~prev_q;

  for (genvar i = 0; i < LAT; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i+1] <= 1'b0;
      else        chain[i+1] <= chain[i];
    end
  end

  assign strobe_o = chain[LAT];

  // R1: a single edge gives a single strobe, never two in a row
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    chain[0] |=> !chain[0]);
endmodule

// File: rtl/coinc_range_chk.sv
module coinc_range_chk #(
  parameter int W  = 12,
  parameter int LO = 650,
  parameter int HI = 2350
) (
  input  logic [W-1:0] value_i,
  output logic         ok_o
);
  always_comb begin
    ok_o = (int'(value_i) >= LO) && (int'(value_i) <= HI);
  end
endmodule

// File: rtl/coinc_capture_fsm.sv
module coinc_capture_fsm
  import coinc_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int WIN_CYC = 100,
  parameter int DROP_W  = 16,
  localparam int CNT_W  = $clog2(WIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_a_i,
  input  logic              stb_b_i,
  input  logic [ADC_W-1:0]  adc_a_i,
  input  logic [ADC_W-1:0]  adc_b_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADC_W-1:0]  first_o,
  output logic [ADC_W-1:0]  second_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic              b_lead_o,
  output logic [DROP_W-1:0] drop_o
);
  localparam logic [CNT_W-1:0]  WIN_V    = CNT_W'(WIN_CYC);
  localparam logic [DROP_W:0]   DROP_MAX = {1'b0, {DROP_W{1'b1}}};

  cap_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              lead_q, lead_d;
  logic [ADC_W-1:0]  first_q, first_d, second_q, second_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              first_en, second_en, drop_en;
  logic              follow_stb;
  logic [1:0]        drop_add;
  logic [DROP_W:0]   drop_sum;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    lead_d    = lead_q;
    first_d   = first_q;
    second_d  = second_q;
    first_en  = 1'b0;
    second_en = 1'b0;
    cnt_inc   = cnt_q + CNT_W'(1);
    follow_stb = lead_q ? stb_a_i : stb_b_i;
    unique case (state_q)
      CAP_IDLE: begin
        if (stb_a_i) begin
          first_en = 1'b1;
          first_d  = adc_a_i;
          lead_d   = 1'b0;
          cnt_d    = '0;
          if (stb_b_i) begin
            second_en = 1'b1;
            second_d  = adc_b_i;
            state_d   = CAP_HOLD;
          end else begin
            state_d   = CAP_WAIT;
          end
        end else if (stb_b_i) begin
          first_en = 1'b1;
          first_d  = adc_b_i;
          lead_d   = 1'b1;
          cnt_d    = '0;
          state_d  = CAP_WAIT;
        end
      end
      CAP_WAIT: begin
        if (follow_stb) begin
          second_en = 1'b1;
          second_d  = lead_q ? adc_a_i : adc_b_i;
          cnt_d     = cnt_inc;
          state_d   = CAP_HOLD;
        end else if (cnt_inc == WIN_V) begin
          cnt_d   = '0;
          state_d = CAP_IDLE;
        end else begin
          cnt_d   = cnt_inc;
        end
      end
      CAP_HOLD: begin
        if (ready_i) state_d = CAP_IDLE;
      end
      default: state_d = CAP_IDLE;
    endcase
  end

  // drop counter, saturating
  always_comb begin
    drop_add = {1'b0, stb_a_i} + {1'b0, stb_b_i};
    drop_sum = {1'b0, drop_q} + {{(DROP_W-1){1'b0}}, drop_add};
    drop_en  = (state_q == CAP_HOLD) && (drop_add != 2'd0);
    drop_d   = (drop_sum > DROP_MAX) ? DROP_MAX[DROP_W-1:0] : drop_sum[DROP_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lead_q  <= lead_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        first_q <= '0;
    else if (first_en) first_q <= first_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         second_q <= '0;
    else if (second_en) second_q <= second_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_q <= '0;
    else if (drop_en) drop_q <= drop_d;
  end

  assign valid_o  = (state_q == CAP_HOLD);
  assign first_o  = first_q;
  assign second_o = second_q;
  assign cycles_o = cnt_q;
  assign b_lead_o = lead_q;
  assign drop_o   = drop_q;

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(first_q) && $stable(second_q)
                               && $stable(cnt_q) && $stable(lead_q)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> !valid_o);

  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAP_WAIT) |-> (cnt_q < WIN_V));

  a_r4_tie_lead_a: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cnt_q == '0) |-> !lead_q);

  a_r8_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (stb_a_i || stb_b_i) && drop_q != DROP_MAX[DROP_W-1:0])
      |=> (drop_q > $past(drop_q)));

  a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> $stable(drop_q));
endmodule

// File: rtl/coinc_capture.sv
module coinc_capture #(
  parameter int ADC_W   = 12,
  parameter int WIN_CYC = 100,
  parameter int ADC_LAT = 2,
  parameter int DROP_W  = 16,
  parameter int LO_LIM  = 650,
  parameter int HI_LIM  = 2350,
  localparam int CNT_W  = $clog2(WIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_a_i,
  input  logic              evt_b_i,
  input  logic [ADC_W-1:0]  adc_a_i,
  input  logic [ADC_W-1:0]  adc_b_i,
  input  logic              rec_ready_i,
  output logic              rec_valid_o,
  output logic [ADC_W-1:0]  rec_first_o,
  output logic [ADC_W-1:0]  rec_second_o,
  output logic [CNT_W-1:0]  rec_cycles_o,
  output logic              rec_b_lead_o,
  output logic              rec_range_ok_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic rst_n_s;
  logic stb_a, stb_b;
  logic ok_first, ok_second;

  coinc_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  coinc_edge_strobe #(.LAT(ADC_LAT)) u_edge_a (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_a_i), .strobe_o(stb_a));
  coinc_edge_strobe #(.LAT(ADC_LAT)) u_edge_b (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_b_i), .strobe_o(stb_b));

  coinc_capture_fsm #(.ADC_W(ADC_W), .WIN_CYC(WIN_CYC), .DROP_W(DROP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .stb_a_i(stb_a), .stb_b_i(stb_b),
    .adc_a_i(adc_a_i), .adc_b_i(adc_b_i), .ready_i(rec_ready_i),
    .valid_o(rec_valid_o), .first_o(rec_first_o), .second_o(rec_second_o),
    .cycles_o(rec_cycles_o), .b_lead_o(rec_b_lead_o), .drop_o(drop_cnt_o));

  coinc_range_chk #(.W(ADC_W), .LO(LO_LIM), .HI(HI_LIM)) u_rng_first (
    .value_i(rec_first_o), .ok_o(ok_first));
  coinc_range_chk #(.W(ADC_W), .LO(LO_LIM), .HI(HI_LIM)) u_rng_second (
    .value_i(rec_second_o), .ok_o(ok_second));

  assign rec_range_ok_o = ok_first & ok_second;

  // R9: nothing is presented while the internal reset is held
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n_s |-> (!rec_valid_o && drop_cnt_o == '0));
endmodule

// File: tb/test_coinc_capture.sv
module test_coinc_capture;
  localparam int ADC_W = 12;
  localparam int WIN   = 20;
  localparam int LAT   = 2;
  localparam int DW    = 4;
  localparam int CW    = $clog2(WIN + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic evt_a, evt_b, ready;
  logic [ADC_W-1:0] adc_a, adc_b;
  logic valid, b_lead, rok;
  logic [ADC_W-1:0] first, second;
  logic [CW-1:0] cycles;
  logic [DW-1:0] drops;

  int checks = 0;
  int fails = 0;
  int exp_drop = 0;
  bit done = 0;

  always #5 clk = ~clk;

  coinc_capture #(.ADC_W(ADC_W), .WIN_CYC(WIN), .ADC_LAT(LAT), .DROP_W(DW)) i_coinc_capture (
    .clk(clk), .rst_n(rst_n), .evt_a_i(evt_a), .evt_b_i(evt_b),
    .adc_a_i(adc_a), .adc_b_i(adc_b), .rec_ready_i(ready),
    .rec_valid_o(valid), .rec_first_o(first), .rec_second_o(second),
    .rec_cycles_o(cycles), .rec_b_lead_o(b_lead), .rec_range_ok_o(rok),
    .drop_cnt_o(drops));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit in_rng(input int v);
    return (v >= 650) && (v <= 2350);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ta: A start, alen: A width, ta2: repeat A (<0 none), tb: B start (<0 none)
  task automatic drive(input int ta, input int alen, input int ta2, input int tb);
    int last;
    last = ta + alen;
    if (ta2 + 2 > last) last = ta2 + 2;
    if (tb + 2 > last) last = tb + 2;
    for (int c = 0; c < last + WIN + LAT + 10; c++) begin
      @(negedge clk);
      evt_a = (ta >= 0 && c >= ta && c < ta + alen) || (ta2 >= 0 && c >= ta2 && c < ta2 + 2);
      evt_b = (tb >= 0 && c >= tb && c < tb + 2);
    end
    @(negedge clk);
    evt_a = 1'b0;
    evt_b = 1'b0;
    idle(2);
  endtask

  task automatic accept();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
    chk(valid == 1'b0, "R7 valid drops after ready", int'(valid), 0);
  endtask

  // d = tB - tA; expected record per R2/R3/R4/R5/R6
  task automatic pair(input int d, input int va, input int vb, input int alen);
    int ad;
    adc_a = ADC_W'(va);
    adc_b = ADC_W'(vb);
    ad = (d < 0) ? -d : d;
    if (d >= 0) drive(0, alen, -1, d);
    else        drive(-d, alen, -1, 0);
    if (ad <= WIN) begin
      chk(valid == 1'b1, "R5 record within window", int'(valid), 1);
      chk(int'(cycles) == ad, "R2/R3 cycle count", int'(cycles), ad);
      chk(int'(b_lead) == ((d < 0) ? 1 : 0), "R3/R4 lead flag", int'(b_lead), (d < 0) ? 1 : 0);
      chk(int'(first) == ((d < 0) ? vb : va), "R2 first sample", int'(first), (d < 0) ? vb : va);
      chk(int'(second) == ((d < 0) ? va : vb), "R3 second sample", int'(second), (d < 0) ? va : vb);
      chk(int'(rok) == int'(in_rng(va) && in_rng(vb)), "R6 range flag", int'(rok),
          int'(in_rng(va) && in_rng(vb)));
      accept();
    end else begin
      chk(valid == 1'b0, "R5 no record past window", int'(valid), 0);
      idle(WIN + 5);
      chk(valid == 1'b0, "R5 re-armed without record", int'(valid), 0);
    end
    chk(int'(drops) == exp_drop, "R8 no drops outside hold", int'(drops), exp_drop);
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk); evt_a = a; evt_b = b;
    @(negedge clk);
    @(negedge clk); evt_a = 1'b0; evt_b = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d, va, vb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; evt_a = 1'b0; evt_b = 1'b0; ready = 1'b0;
    adc_a = '0; adc_b = '0;
    idle(5);
    chk(valid == 1'b0, "R9 reset valid", int'(valid), 0);
    chk(drops == '0, "R9 reset drops", int'(drops), 0);
    rst_n = 1'b1;
    idle(4);

    // directed corners
    pair(7, 1000, 2000, 2);            // R2
    pair(-9, 1200, 1800, 2);           // R3
    pair(0, 700, 2300, 2);             // R4 tie
    pair(WIN, 650, 2350, 2);           // R5 boundary accepted, R6 inclusive
    pair(-WIN, 649, 1500, 2);          // R6 low out
    pair(WIN + 1, 1000, 1000, 2);      // R5 expired
    pair(-(WIN + 3), 1000, 2351, 2);   // R5 expired, B leads
    pair(5, 1100, 1900, 40);           // R1 long A pulse is one event
    pair(1, 4095, 0, 2);               // R6 extremes, minimum offset

    // R10: A at 0, repeat A at 6, B at 13
    adc_a = 12'd900; adc_b = 12'd1700;
    drive(0, 2, 6, 13);
    chk(valid == 1'b1, "R10 record present", int'(valid), 1);
    chk(int'(cycles) == 13, "R10 count from first leader", int'(cycles), 13);
    chk(b_lead == 1'b0, "R10 leader kept", int'(b_lead), 0);
    accept();

    // random pairs
    for (int k = 0; k < 40; k++) begin
      d  = int'($urandom_range(0, 2 * (WIN + 4))) - (WIN + 4);
      va = (k % 3 == 0) ? int'($urandom_range(0, 4095)) : int'($urandom_range(650, 2350));
      vb = (k % 4 == 0) ? int'($urandom_range(0, 4095)) : int'($urandom_range(650, 2350));
      pair(d, va, vb, int'($urandom_range(1, 4)));
    end

    // R8: drops while holding, record stays put (R7)
    adc_a = 12'd1111; adc_b = 12'd2222;
    drive(0, 2, -1, 3);
    chk(valid == 1'b1, "R8 record held", int'(valid), 1);
    pulse(1, 0); pulse(1, 0); pulse(0, 1); pulse(1, 1);
    idle(LAT + 4);
    exp_drop = 5;
    chk(int'(drops) == exp_drop, "R8 drop count", int'(drops), exp_drop);
    chk(valid == 1'b1, "R7 still valid without ready", int'(valid), 1);
    chk(int'(first) == 1111 && int'(second) == 2222 && int'(cycles) == 3,
        "R7 fields stable", int'(first), 1111);
    for (int i = 0; i < 6; i++) pulse(1, 1);
    idle(LAT + 4);
    exp_drop = 15;
    chk(int'(drops) == exp_drop, "R8 saturation", int'(drops), exp_drop);
    accept();
    pair(4, 800, 900, 2);
    chk(int'(drops) == 15, "R8 saturated count kept", int'(drops), 15);

    // R9: reset mid-hold
    drive(0, 2, -1, 2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0, "R9 reset clears valid", int'(valid), 0);
    chk(drops == '0, "R9 reset clears drops", int'(drops), 0);
    rst_n = 1'b1;
    idle(4);
    exp_drop = 0;
    pair(-2, 1500, 1600, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule